// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a serial-input voltage DAC. A host sends 24-bit frames over three wires: an active-low frame select, a serial clock and a data line. The three pins are oversampled in a faster system clock, at least four times the serial clock rate. Each pin passes through a two-flop synchronizer. Falling edges of the serial clock shift data into a frame register, most significant bit first.

When exactly 24 falling edges have been taken inside one frame, the block decodes the frame. It updates a held DAC code and a two-bit power mode, and it pulses an update strobe for one cycle. If the frame select rises before the 24th edge, the frame is thrown away with no effect. A parameter sets the resolution to 16 or 12 bits. The code is always taken from the top of the 16-bit data field.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset the code output is all zeros, the power mode output is 00 and the update strobe is low.
- R2: A complete frame is sent MSB first. Frame bits 17:16 are the mode field and bits 15:0 are the data word; in the 16-bit build the code output becomes bits 15:0.
- R3: Frame bits 23:18 have no effect on the code or the mode.
- R4: The mode field is stored as sent: 00 normal, 01 power-down with about 1 kΩ to ground, 10 power-down with about 100 kΩ to ground, 11 power-down with a high-impedance output.
- R5: The commit happens on exactly the 24th falling serial clock edge of a frame. The strobe goes high for one system clock cycle and the mode updates in the same cycle.
- R6: If the frame select rises after fewer than 24 falling edges, the code, the mode and the strobe are unaffected. The partial frame is cleared, so the next full frame decodes correctly.
- R7: Falling edges after the 24th are ignored until the frame select rises and then falls again.
- R8: A frame whose mode field is not 00 updates only the mode; the stored code keeps its previous value.
- R9: With RES = 12 the code output is frame bits 15:4, and bits 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_n_i | input | 1 | Active-low frame select (asynchronous) |
| sck_i | input | 1 | Serial clock; data is sampled on its falling edge (asynchronous) |
| sdi_i | input | 1 | Serial data, MSB first (asynchronous) |
| code_o | output | RES | Held DAC code |
| pwr_mode_o | output | 2 | Power mode: 00 normal, 01 1 kΩ, 10 100 kΩ, 11 high-Z |
| update_o | output | 1 | One-cycle pulse on each commit |

## Verification
Some properties are checked by assertions on every cycle. The held code and mode never move outside a commit cycle. A power-down commit never changes the code. The strobe never lasts more than one cycle, and the edge counter never exceeds the frame length. Other behaviours need the bench scenarios. These are the field positions, that the header bits are ignored, and that aborts after 10 and after 23 edges leave no trace. They also cover surplus edges after a commit and the 12-bit slice, which the bench shows by comparing each strobe against a queue of expected results.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam int MODE_LO = 16;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    PWR_ON      = 2'b00,
    PWR_DN_1K   = 2'b01,
    PWR_DN_100K = 2'b10,
    PWR_DN_HIZ  = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic act_o,
  output logic start_o,
  output logic stop_o,
  output logic fall_o,
  output logic bit_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE = 3'b110; // {fs_n, sck, sdi}

  logic [NPIN-1:0] stg [STAGES];
  logic [NPIN-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE;
        else if (g == 0) stg[g] <= {fs_n_i, sck_i, sdi_i};
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= stg[STAGES-1];
  end

  logic [NPIN-1:0] cur;
  assign cur     = stg[STAGES-1];
  assign act_o   = ~cur[2];
  assign start_o = prev_q[2] & ~cur[2];
  assign stop_o  = ~prev_q[2] & cur[2];
  assign fall_o  = prev_q[1] & ~cur[1];
  assign bit_o   = cur[0];
endmodule

// File: rtl/dac_rx_framer.sv
module dac_rx_framer
  import dac_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               act_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               fall_i,
  input  logic               bit_i,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;
  logic [FRAME_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[FRAME_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      commit_o <= 1'b0;
      frame_o  <= '0;
    end else begin
      commit_o <= 1'b0;
      if (start_i || stop_i) begin
        sh_q   <= '0;
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (act_i && fall_i && !done_q) begin
        sh_q <= sh_nxt;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          cnt_q    <= CNT_W'(FRAME_W);
          done_q   <= 1'b1;
          commit_o <= 1'b1;
          frame_o  <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: the edge count is bounded by one frame
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_W));

  // R5: a commit is never repeated on the next cycle
  a_r5_commit_single: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);
endmodule

// File: rtl/dac_rx_regs.sv
module dac_rx_regs
  import dac_rx_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [RES-1:0]     code_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               strobe_o
);
  localparam int LSB = DATA_W - RES;

  logic [RES-1:0]    slice;
  logic [MODE_W-1:0] fmode;

  generate
    if (LSB > 0) begin : g_reduced
      assign slice = frame_i[DATA_W-1:LSB];
    end else begin : g_full
      assign slice = frame_i[DATA_W-1:0];
    end
  endgenerate

  assign fmode = frame_i[MODE_LO+MODE_W-1:MODE_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '0;
      mode_o   <= PWR_ON;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= commit_i;
      if (commit_i) begin
        mode_o <= fmode;
        if (fmode == PWR_ON) code_o <= slice;
      end
    end
  end

  // R6: held state moves only on a commit
  a_r6_hold_no_commit: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(code_o) && $stable(mode_o)));

  // R8: a power-down commit keeps the code
  a_r8_pd_keeps_code: assert property (@(posedge clk) disable iff (rst)
    (commit_i && fmode != PWR_ON) |=> $stable(code_o));

  // R5: strobe lasts one cycle
  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_rx_pkg::*;
#(
  parameter int RES         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [RES-1:0]    code_o,
  output logic [MODE_W-1:0] pwr_mode_o,
  output logic              update_o
);
  logic act, start, stop, fall, sbit, commit;
  logic [FRAME_W-1:0] frame;

  dac_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .fs_n_i(fs_n_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .act_o(act), .start_o(start), .stop_o(stop), .fall_o(fall), .bit_o(sbit)
  );

  dac_rx_framer u_framer (
    .clk(clk), .rst(rst), .act_i(act), .start_i(start), .stop_i(stop),
    .fall_i(fall), .bit_i(sbit), .commit_o(commit), .frame_o(frame)
  );

  dac_rx_regs #(.RES(RES)) u_regs (
    .clk(clk), .rst(rst), .commit_i(commit), .frame_i(frame),
    .code_o(code_o), .mode_o(pwr_mode_o), .strobe_o(update_o)
  );
endmodule

// File: tb/dac_cmd_rx_bench.sv
module dac_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic [15:0] code16;
  logic [11:0] code12;
  logic [1:0]  mode16, mode12;
  logic        upd16, upd12;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [15:0] q_code[$];
  logic [1:0]  q_mode[$];
  logic [15:0] model_code = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_rx #(.RES(16)) u_dac_cmd_rx (
    .clk(clk), .rst(rst), .fs_n_i(fs_n), .sck_i(sck), .sdi_i(sdi),
    .code_o(code16), .pwr_mode_o(mode16), .update_o(upd16));

  dac_cmd_rx #(.RES(12)) u_dac_cmd_rx12 (
    .clk(clk), .rst(rst), .fs_n_i(fs_n), .sck_i(sck), .sdi_i(sdi),
    .code_o(code12), .pwr_mode_o(mode12), .update_o(upd12));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // drive nfalls falling edges carrying frame bits MSB first; extra edges send ones
  task automatic send(input logic [23:0] fr, input int nfalls, input bit full);
    if (full) begin
      q_mode.push_back(fr[17:16]);
      if (fr[17:16] == 2'b00) model_code = fr[15:0];
      q_code.push_back(model_code);
    end
    fs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nfalls; i++) begin
      sdi = (i < 24) ? fr[23-i] : 1'b1;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    sck = 1'b1;
    wait_clk(HALF);
    fs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (upd16 || upd12)) begin
      if (q_code.size() == 0) begin
        check(1'b0, "R6/R7 unexpected strobe", {31'h0, upd16}, 32'h0);
      end else begin
        logic [15:0] ec;
        logic [1:0]  em;
        ec = q_code.pop_front();
        em = q_mode.pop_front();
        check(code16 == ec, "R2/R8 code16", {16'h0, code16}, {16'h0, ec});
        check(mode16 == em, "R4 mode", {30'h0, mode16}, {30'h0, em});
        check(code12 == ec[15:4] && mode12 == em, "R9 code12", {20'h0, code12}, {20'h0, ec[15:4]});
        check(upd16 && upd12, "R5 strobe alignment", {30'h0, upd16, upd12}, 32'h3);
      end
    end
  end

  // R5: strobe is one cycle wide
  always @(negedge clk) begin
    if (!rst && upd16) begin
      @(negedge clk);
      check(!upd16, "R5 strobe width", {31'h0, upd16}, 32'h0);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    wait_clk(150000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(code16 == 16'h0, "R1 code reset", {16'h0, code16}, 32'h0);
    check(mode16 == 2'b00, "R1 mode reset", {30'h0, mode16}, 32'h0);
    check(!upd16, "R1 strobe reset", {31'h0, upd16}, 32'h0);

    // R2 R3: junk header bits
    send({6'b101101, 2'b00, 16'hA5C3}, 24, 1);
    // R4 R8: power-down modes keep code
    send({6'b000000, 2'b01, 16'h1234}, 24, 1);
    send({6'b111111, 2'b10, 16'h5555}, 24, 1);
    send({6'b010101, 2'b11, 16'h0F0F}, 24, 1);
    send({6'b000000, 2'b00, 16'hFFFF}, 24, 1);
    @(negedge clk);
    check(code16 == 16'hFFFF && mode16 == 2'b00, "R2 after normal frame", {16'h0, code16}, 32'hFFFF);

    // R6: aborts after 10 and 23 edges
    send({6'h3F, 2'b11, 16'h0000}, 10, 0);
    @(negedge clk);
    check(code16 == 16'hFFFF && mode16 == 2'b00, "R6 abort 10", {14'h0, mode16, code16}, 32'h0FFFF);
    send({6'h00, 2'b10, 16'h1111}, 23, 0);
    @(negedge clk);
    check(code16 == 16'hFFFF && mode16 == 2'b00, "R6 abort 23", {14'h0, mode16, code16}, 32'h0FFFF);
    send({6'h00, 2'b00, 16'h0001}, 24, 1);

    // R7: surplus edges ignored
    send({6'h00, 2'b00, 16'h8010}, 30, 1);
    @(negedge clk);
    check(code16 == 16'h8010 && mode16 == 2'b00, "R7 surplus edges", {14'h0, mode16, code16}, 32'h08010);

    // R9: low nibble ignored in 12-bit build
    send({6'h00, 2'b00, 16'h000F}, 24, 1);
    @(negedge clk);
    check(code12 == 12'h000, "R9 low bits dropped", {20'h0, code12}, 32'h0);

    wait_clk(20);
    check(q_code.size() == 0, "R5 all commits seen", q_code.size(), 32'h0);
    finish_run();
  end
endmodule